// File: doc/BRIEF.md
# Segmented Data Address Generator

This block turns a 16-bit pointer offset into a full 24-bit data address by placing an 8-bit segment number above it. It keeps two segment registers, a primary (data) segment and an alternate (extra) segment. It also keeps an 8-bit routing register. Bits 0 to 6 of the routing register choose a segment for pointers 0 to 6, and bit 7 is a write-enable for the alternate segment.

A request carries a pointer index, an offset and a stack flag, and the address comes back in the same cycle with no register on the path. Software-side logic updates the registers through a small write port that selects a register by address, and reads them back through an addressed read port. A register write changes the address formed on the next clock edge.

Top module: `seg_addr_gen`

## Requirements
- R1: The output address is `{segment, offset}`: bits 23:16 hold the selected segment register and bits 15:0 hold the request offset unchanged, with no carry between the two fields.
- R2: For a non-stack request with index k in 0..6, routing bit k equal to 0 selects the primary segment and 1 selects the alternate segment.
- R3: When the stack flag is set, the primary segment is used no matter what the index or the routing bits are, and no error is raised.
- R4: Reset clears the routing register, the primary segment and the alternate segment to 0.
- R5: The register address decoding is 0 = routing, 1 = primary segment, 2 = alternate segment, 3 = unused. A write to address 3 changes no register.
- R6: A write to the alternate segment has no effect while routing bit 7 is 0, and takes effect while it is 1.
- R7: An index of 7 with the stack flag clear raises `err` and uses the primary segment. `err` is 0 for every other request.
- R8: A register write becomes visible at the address output and the read port only after the clock edge on which it is accepted.
- R9: The read port returns the register selected by `rd_addr` with the same decoding as R5, and returns 0 for address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Register select for the read |
| rd_data | output | 8 | Read data |
| req_idx | input | 3 | Pointer index |
| req_off | input | 16 | Pointer offset |
| req_stack | input | 1 | Stack access flag |
| addr | output | 24 | Formed 24-bit address |
| err | output | 1 | Invalid pointer index |

## Verification
The assertions assume that the request inputs and the write inputs are known (not X/Z) at every clock edge after reset. They also assume that a value held on `wr_data` at an edge with `wr_en` high is the intended write. The bench drives inputs only on falling edges and releases `wr_en` after one cycle, so every write is a single well-defined event. The checks read the address during the low phase of the clock, after a write has settled and before the next edge.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OFF_W = 16,
  parameter int SEG_W = 8,
  parameter int NPTR  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  logic [SEG_W-1:0]       wr_data,
  input  logic [1:0]             rd_addr,
  output logic [SEG_W-1:0]       rd_data,
  input  logic [2:0]             req_idx,
  input  logic [OFF_W-1:0]       req_off,
  input  logic                   req_stack,
  output logic [SEG_W+OFF_W-1:0] addr,
  output logic                   err
);
  localparam logic [1:0] A_ROUTE = 2'd0, A_PRI = 2'd1, A_ALT = 2'd2;
  localparam int ALT_WE_BIT = SEG_W - 1;

  logic [SEG_W-1:0] route_q, pri_q, alt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      pri_q   <= '0;
      alt_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_ROUTE: route_q <= wr_data;
        A_PRI:   pri_q   <= wr_data;
        A_ALT:   if (route_q[ALT_WE_BIT]) alt_q <= wr_data;
        default: ;
      endcase
    end
  end

  logic bad_idx, use_alt;
  assign bad_idx = !req_stack && (int'(req_idx) >= NPTR);
  assign use_alt = !req_stack && !bad_idx && route_q[req_idx];
  assign err     = bad_idx;
  assign addr    = {use_alt ? alt_q : pri_q, req_off};

  always_comb begin
    case (rd_addr)
      A_ROUTE: rd_data = route_q;
      A_PRI:   rd_data = pri_q;
      A_ALT:   rd_data = alt_q;
      default: rd_data = '0;
    endcase
  end
endmodule

module seg_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic [1:0]  rd_addr,
  input logic [7:0]  rd_data,
  input logic [2:0]  req_idx,
  input logic [15:0] req_off,
  input logic        req_stack,
  input logic [23:0] addr,
  input logic        err
);
  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr[15:0] == req_off);
  // R7
  err_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err == (!req_stack && req_idx == 3'd7));
  // R3
  stack_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_stack |-> !err);
  // R9
  unused_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 2'd3 |-> rd_data == 8'd0);
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_addr == 2'd1) |=> (rd_addr != 2'd1 || $stable(rd_data)));
  // R5
  pri_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && rd_addr == 2'd1) |=>
      (rd_addr != 2'd1 || rd_data == $past(wr_data)));
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (.*);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [2:0] req_idx = 0;
  logic [15:0] req_off = 0;
  logic req_stack = 0;
  logic [23:0] addr;
  logic err;
  int vecs = 0, bad = 0;

  always #2.5 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [7:0] exp);
    @(negedge clk); rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic req(string r, logic [2:0] i, logic [15:0] o, logic s,
                     logic [23:0] ea, logic ee);
    @(negedge clk); req_idx = i; req_off = o; req_stack = s; #1;
    chk(r, addr, ea);
    chk(r, err, ee);
  endtask

  task automatic t_reset;
    rd("R4", 0, 0); rd("R4", 1, 0); rd("R4", 2, 0);
    req("R4", 3, 16'h1234, 0, 24'h001234, 0);
  endtask

  task automatic t_route;
    wr(1, 8'h5A);
    wr(0, 8'h80);
    wr(2, 8'hC3);
    rd("R6", 2, 8'hC3);
    wr(0, 8'h2A);
    for (int k = 0; k < 7; k++)
      req("R2", k[2:0], 16'hFFFF, 0, {((8'h2A >> k) & 1) ? 8'hC3 : 8'h5A, 16'hFFFF}, 0);
    req("R1", 1, 16'h0000, 0, 24'hC30000, 0);
  endtask

  task automatic t_stack;
    for (int k = 0; k < 8; k++)
      req("R3", k[2:0], 16'hBEEF, 1, 24'h5ABEEF, 0);
  endtask

  task automatic t_lock;
    wr(2, 8'h11);
    rd("R6", 2, 8'hC3);
    req("R6", 1, 16'h0001, 0, 24'hC30001, 0);
  endtask

  task automatic t_bad;
    wr(0, 8'hFF);
    req("R7", 7, 16'h4321, 0, 24'h5A4321, 1);
  endtask

  task automatic t_unused;
    wr(3, 8'h77);
    rd("R5", 0, 8'hFF); rd("R5", 1, 8'h5A); rd("R5", 2, 8'hC3);
    rd("R9", 3, 8'h00);
  endtask

  task automatic t_timing;
    req_idx = 0; req_stack = 0; req_off = 16'h0042;
    @(negedge clk); wr_en = 1; wr_addr = 1; wr_data = 8'h99; rd_addr = 1; #1;
    chk("R8", addr, 24'hC30042);
    chk("R8", rd_data, 8'h5A);
    @(negedge clk); wr_en = 0; wr_addr = 0; rd_addr = 0; #1;
    chk("R8", addr, 24'hC30042);
    wr(0, 8'h00);
    req("R8", 0, 16'h0042, 0, 24'h990042, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset(); t_route(); t_stack(); t_lock();
        t_bad(); t_unused(); t_timing();
      end
      begin
        repeat (20000) @(posedge clk);
        bad++; vecs++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule